// File: doc/BRIEF.md
# Peripheral-to-Memory Block Copy Engine

This block moves a run of bytes from a peripheral into system memory without the processor executing any load or store. Software first loads a destination address and a byte count, then arms the channel through a small register port. Once the channel is armed, a request from the peripheral makes the engine ask the processor for the system bus with a hold request. It waits for the hold acknowledge, and only then signals the peripheral that service has begun.

With the bus granted, the engine runs one bus cycle per byte. In that cycle it strobes a read to the peripheral, passes the returned byte onto the memory data lines, and drives the current destination address with a memory write strobe. The address steps by one after each byte. When the number of bytes moved equals the programmed count, the engine drops the hold request, gives the bus back and raises a completion flag. The flag can drive an interrupt line and is cleared by a register write. While the engine does not own the bus, its bus outputs stay at zero and its output enable is low.

Top module: `p2m_dma`

## Requirements
- R1: After reset, hold_req, dack, bus_oe, per_rd, mem_wr, done and irq are all 0, and mem_addr is 0.
- R2: Register writes use cfg_sel 0 for the destination address, 1 for the byte count (low 8 bits of cfg_wdata) and 2 for control. In the control word, bit 0 arms the channel, bit 1 clears done and bit 2 is the interrupt enable. A request on dreq has no effect unless the channel is armed. When dreq is sampled high while the channel is armed, hold_req is 1 from the next cycle on.
- R3: While hold_req is 1 and hlda has not yet been sampled high, dack, bus_oe, per_rd and mem_wr stay 0. dack and bus_oe rise in the cycle after hlda is sampled high, and per_rd and mem_wr are still 0 in that cycle.
- R4: In the k-th byte cycle (k counting from 0), per_rd and mem_wr are both 1, mem_wdata equals per_rdata, and mem_addr equals the programmed destination plus k, modulo 2^16.
- R5: Byte cycles follow one another without gaps, starting one cycle after dack rises. Their number equals the programmed byte count.
- R6: In the cycle after the last byte cycle, hold_req, dack, bus_oe, per_rd and mem_wr are 0, and done is 1.
- R7: Whenever bus_oe is 0, mem_addr, mem_wdata, per_rd and mem_wr are 0.
- R8: irq equals done AND the interrupt enable taken from the last arming control write. A control write with bit 1 set clears done from the next cycle, and a write that arms the channel also clears it.
- R9: Arming with a byte count of 0 sets done in the next cycle and never raises hold_req, even when dreq is high.
- R10: While the channel is armed or transferring, writes to the address and count registers are ignored, and so is the arm bit. The block in progress and the next block armed without reprogramming use the earlier values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 control |
| cfg_wdata | input | 16 | Register write data |
| dreq | input | 1 | Service request from the peripheral |
| dack | output | 1 | Service acknowledge to the peripheral |
| per_rd | output | 1 | Read strobe to the peripheral |
| per_rdata | input | 8 | Byte returned by the peripheral |
| hold_req | output | 1 | Bus request to the processor |
| hlda | input | 1 | Bus grant from the processor |
| bus_oe | output | 1 | Enable for the engine's bus drivers |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_wr | output | 1 | Memory write strobe |
| done | output | 1 | Block completion flag |
| irq | output | 1 | Completion interrupt |

## Verification
The checks assume that the processor behaves correctly on the bus. Once it raises hlda in answer to hold_req, it keeps hlda high until the engine drops the request, and it never grants the bus unasked. The stimulus holds hlda low until hold_req has been seen for the chosen number of cycles, keeps it high through the whole burst and drops it only after the release. dreq is pulsed only while the channel is idle or armed, and register writes made while the channel is busy fall inside the armed wait or the byte burst. This way the ignore rule is exercised in both states.

// File: rtl/p2m_dma_pkg.sv
package p2m_dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_HOLD  = 3'd2,
    ST_ACK   = 3'd3,
    ST_XFER  = 3'd4
  } dma_state_e;

  localparam logic [1:0] SEL_DEST = 2'd0;
  localparam logic [1:0] SEL_SIZE = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam int CTRL_ARM_BIT = 0;
  localparam int CTRL_CLR_BIT = 1;
  localparam int CTRL_IEN_BIT = 2;

endpackage

// File: rtl/p2m_dma_regs.sv
module p2m_dma_regs
  import p2m_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              busy,
  input  logic              blk_end,
  output logic [ADDR_W-1:0] dest_q,
  output logic [CNT_W-1:0]  size_q,
  output logic              arm_go,
  output logic              zero_done,
  output logic              done_q,
  output logic              ien_q
);

  logic accept;
  logic ctrl_wr;
  logic arm_req;
  logic clr_req;
  logic size_zero;

  assign accept    = cfg_wr && !busy;
  assign ctrl_wr   = cfg_wr && (cfg_sel == SEL_CTRL);
  assign arm_req   = accept && (cfg_sel == SEL_CTRL) && cfg_wdata[CTRL_ARM_BIT];
  assign clr_req   = ctrl_wr && cfg_wdata[CTRL_CLR_BIT];
  assign size_zero = (size_q == '0);
  assign arm_go    = arm_req && !size_zero;
  assign zero_done = arm_req && size_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dest_q <= '0;
      size_q <= '0;
      ien_q  <= 1'b0;
    end else if (accept) begin
      if (cfg_sel == SEL_DEST) dest_q <= cfg_wdata;
      if (cfg_sel == SEL_SIZE) size_q <= cfg_wdata[CNT_W-1:0];
      if (cfg_sel == SEL_CTRL) ien_q  <= cfg_wdata[CTRL_IEN_BIT];
    end
  end

  // Completion flag: setting wins over clearing in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)                     done_q <= 1'b0;
    else if (blk_end || zero_done)  done_q <= 1'b1;
    else if (clr_req || arm_go)     done_q <= 1'b0;
  end

  assert_busy_dest_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_wr) |=> (dest_q == $past(dest_q) && size_q == $past(size_q)));

  assert_zero_sets_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    zero_done |=> done_q);

endmodule

// File: rtl/p2m_dma_ctrl.sv
module p2m_dma_ctrl
  import p2m_dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm_go,
  input  logic dreq,
  input  logic hlda,
  input  logic last_beat,
  output logic hold_req,
  output logic dack,
  output logic bus_own,
  output logic beat,
  output logic busy,
  output logic blk_end
);

  dma_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (arm_go)    state_d = ST_ARMED;
      ST_ARMED: if (dreq)      state_d = ST_HOLD;
      ST_HOLD:  if (hlda)      state_d = ST_ACK;
      ST_ACK:                  state_d = ST_XFER;
      ST_XFER:  if (last_beat) state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign hold_req = (state_q == ST_HOLD) || (state_q == ST_ACK) || (state_q == ST_XFER);
  assign bus_own  = (state_q == ST_ACK) || (state_q == ST_XFER);
  assign dack     = bus_own;
  assign beat     = (state_q == ST_XFER);
  assign busy     = (state_q != ST_IDLE);
  assign blk_end  = beat && last_beat;

  assert_wait_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && !hlda) |=> (state_q == ST_HOLD && !dack));

  assert_ack_under_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> hold_req);

  assert_release_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |=> (!hold_req && !dack && !beat));

  assert_armed_needs_dreq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARMED && !dreq) |=> !hold_req);

endmodule

// File: rtl/p2m_dma_addr.sv
module p2m_dma_addr #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_go,
  input  logic              beat,
  input  logic [ADDR_W-1:0] dest_q,
  input  logic [CNT_W-1:0]  size_q,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              last_beat
);

  logic [CNT_W-1:0] cnt_q;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic is_last(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] n);
    return (c + 1'b1) == n;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      cnt_q    <= '0;
    end else if (arm_go) begin
      cur_addr <= dest_q;
      cnt_q    <= '0;
    end else if (beat) begin
      cur_addr <= step_addr(cur_addr);
      cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign last_beat = is_last(cnt_q, size_q);

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !last_beat) |=> (cur_addr == ADDR_W'($past(cur_addr) + 1'b1)));

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> (cnt_q < size_q));

endmodule

// File: rtl/p2m_dma.sv
module p2m_dma
  import p2m_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              dreq,
  output logic              dack,
  output logic              per_rd,
  input  logic [DATA_W-1:0] per_rdata,
  output logic              hold_req,
  input  logic              hlda,
  output logic              bus_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wr,
  output logic              done,
  output logic              irq
);

  logic [ADDR_W-1:0] dest_q;
  logic [CNT_W-1:0]  size_q;
  logic [ADDR_W-1:0] cur_addr;
  logic arm_go, zero_done, done_q, ien_q;
  logic busy, blk_end, last_beat, beat, bus_own;

  p2m_dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .blk_end(blk_end),
    .dest_q(dest_q), .size_q(size_q), .arm_go(arm_go),
    .zero_done(zero_done), .done_q(done_q), .ien_q(ien_q)
  );

  p2m_dma_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm_go(arm_go), .dreq(dreq), .hlda(hlda),
    .last_beat(last_beat), .hold_req(hold_req), .dack(dack),
    .bus_own(bus_own), .beat(beat), .busy(busy), .blk_end(blk_end)
  );

  p2m_dma_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .arm_go(arm_go), .beat(beat),
    .dest_q(dest_q), .size_q(size_q), .cur_addr(cur_addr),
    .last_beat(last_beat)
  );

  // Bus drivers are parked at zero unless the engine owns the bus.
  assign bus_oe    = bus_own;
  assign mem_addr  = bus_own ? cur_addr : '0;
  assign mem_wdata = beat ? per_rdata : '0;
  assign mem_wr    = beat;
  assign per_rd    = beat;
  assign done      = done_q;
  assign irq       = done_q && ien_q;

  assert_write_owned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (hold_req && dack && hlda));

  assert_quiet_unowned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_req |-> (!bus_oe && !mem_wr && !per_rd));

  assert_zero_no_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    zero_done |=> !hold_req);

endmodule

// File: tb/p2m_dma_bench.sv
module p2m_dma_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        dreq = 1'b0;
  logic        hlda = 1'b0;
  logic [7:0]  per_rdata = 8'd0;
  logic        dack, per_rd, hold_req, bus_oe, mem_wr, done, irq;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  p2m_dma u_p2m_dma (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .dreq(dreq), .dack(dack), .per_rd(per_rd),
    .per_rdata(per_rdata), .hold_req(hold_req), .hlda(hlda),
    .bus_oe(bus_oe), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wr(mem_wr), .done(done), .irq(irq)
  );

  // {dest[15:0], size[7:0], dreq_wait[7:0], hlda_wait[7:0], flags[7:0]}
  // flags bit0: write registers during the burst, bit1: interrupt enable
  localparam logic [47:0] VECS [4] = '{
    {16'h1000, 8'd5,  8'd0, 8'd0, 8'h03},
    {16'h2A40, 8'd1,  8'd3, 8'd2, 8'h00},
    {16'hFFFE, 8'd4,  8'd1, 8'd4, 8'h02},
    {16'h0100, 8'd12, 8'd2, 8'd1, 8'h01}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic run_block(input logic [15:0] dest, input logic [7:0] size,
                           input int dwait, input int hwait,
                           input logic [7:0] fl, input bit prog,
                           input bit armed_write);
    logic ien;
    ien = fl[1];
    if (prog) begin
      reg_wr(2'd0, dest);
      reg_wr(2'd1, {8'd0, size});
    end
    reg_wr(2'd2, {13'd0, ien, 1'b0, 1'b1});
    chk(done == 1'b0, "R8 arm clears done", done, 0);
    if (armed_write) begin
      reg_wr(2'd0, 16'h7777);   // R10: armed, must be ignored
      reg_wr(2'd1, 16'h0002);
    end
    for (int i = 0; i < dwait; i++) begin
      @(negedge clk);
      chk(hold_req == 1'b0, "R2 no hold before dreq", hold_req, 0);
    end
    dreq = 1'b1;
    @(negedge clk);
    dreq = 1'b0;
    chk(hold_req == 1'b1, "R2 hold after dreq", hold_req, 1);
    chk(dack == 1'b0, "R3 dack before grant", dack, 0);
    for (int i = 0; i < hwait; i++) begin
      @(negedge clk);
      chk(hold_req == 1'b1 && dack == 1'b0 && bus_oe == 1'b0 && mem_wr == 1'b0,
          "R3 waiting for grant", {hold_req, dack, bus_oe, mem_wr}, 4'b1000);
    end
    hlda = 1'b1;
    @(negedge clk);
    chk(dack == 1'b1 && bus_oe == 1'b1, "R3 dack after grant", {dack, bus_oe}, 2'b11);
    chk(per_rd == 1'b0 && mem_wr == 1'b0, "R3 no strobe in ack cycle",
        {per_rd, mem_wr}, 2'b00);
    @(negedge clk);
    for (int k = 0; k < size; k++) begin
      per_rdata = 8'(8'hA5 ^ (k * 8'd29));
      #0.5;
      chk(per_rd == 1'b1 && mem_wr == 1'b1, "R5 byte cycle strobes",
          {per_rd, mem_wr}, 2'b11);
      chk(mem_addr == 16'(dest + 16'(k)), "R4 address", mem_addr, 16'(dest + 16'(k)));
      chk(mem_wdata == per_rdata, "R4 data passthrough", mem_wdata, per_rdata);
      if (fl[0] && k == 1) begin cfg_wr = 1'b1; cfg_sel = 2'd0; cfg_wdata = 16'h5555; end
      if (fl[0] && k == 2) begin cfg_wr = 1'b1; cfg_sel = 2'd1; cfg_wdata = 16'h0003; end
      if (fl[0] && k == 3) begin cfg_wr = 1'b1; cfg_sel = 2'd2; cfg_wdata = 16'h0001; end
      if (fl[0] && k == 4) cfg_wr = 1'b0;
      @(negedge clk);
    end
    cfg_wr = 1'b0;
    chk(hold_req == 1'b0 && dack == 1'b0 && bus_oe == 1'b0, "R6 bus released",
        {hold_req, dack, bus_oe}, 3'b000);
    chk(per_rd == 1'b0 && mem_wr == 1'b0 && mem_addr == 16'd0 && mem_wdata == 8'd0,
        "R7 outputs parked", {per_rd, mem_wr, mem_addr}, 0);
    chk(done == 1'b1, "R6 done set", done, 1);
    chk(irq == ien, "R8 irq follows enable", irq, ien);
    hlda = 1'b0;
    @(negedge clk);
    chk(hold_req == 1'b0, "R5 no extra cycle", hold_req, 0);
    reg_wr(2'd2, 16'h0002);
    chk(done == 1'b0 && irq == 1'b0, "R8 clear done", {done, irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(hold_req == 0 && dack == 0 && bus_oe == 0 && per_rd == 0 && mem_wr == 0
        && done == 0 && irq == 0 && mem_addr == 0, "R1 reset state",
        {hold_req, dack, bus_oe, per_rd, mem_wr, done, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: a request while unarmed is ignored
    dreq = 1'b1;
    repeat (3) @(negedge clk);
    chk(hold_req == 1'b0, "R2 unarmed dreq ignored", hold_req, 0);
    dreq = 1'b0;

    for (int v = 0; v < 4; v++) begin
      run_block(VECS[v][47:32], VECS[v][31:24], int'(VECS[v][23:16]),
                int'(VECS[v][15:8]), VECS[v][7:0], 1'b1, 1'b0);
    end

    // R10: re-arm without programming; earlier values must persist
    run_block(16'h0100, 8'd12, 1, 1, 8'h00, 1'b0, 1'b1);

    // R9: zero-size block completes at once, never requests the bus
    reg_wr(2'd1, 16'h0000);
    dreq = 1'b1;
    reg_wr(2'd2, 16'h0005);
    chk(done == 1'b1 && hold_req == 1'b0, "R9 zero size done", {done, hold_req}, 2'b10);
    chk(irq == 1'b1, "R8 irq on zero size", irq, 1);
    repeat (4) @(negedge clk);
    chk(hold_req == 1'b0, "R9 no hold with dreq high", hold_req, 0);
    dreq = 1'b0;
    reg_wr(2'd2, 16'h0002);
    chk(done == 1'b0, "R8 clear after zero size", done, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule